// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a load/store requester and a next-level memory port. Each line holds four 32-bit words. Each request address is split into a tag, a line index and a word offset. The index selects one line. If the stored tag matches and the line is valid, the access is a hit and is served from local storage. Otherwise it is a miss. A miss allocates the line, for loads and for stores alike. Each line is tracked as invalid, clean-valid or dirty-valid.

On a miss the controller sends a single read request to the next level. The request carries the address of the word that was asked for. Memory answers with four beats: the requested word first, then the following words, wrapping around the line. That first word goes back to the requester as soon as it lands, while the other beats are still gathered in a fill buffer. The complete line is installed once all four beats are in.

If the line being replaced is dirty, it is first copied into a victim buffer. It is written back to the next level only after the refill read has been issued. The requester waits through the whole sequence, which covers the fill, the install and any copyback. Only then is a new request accepted.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address produces a next-level read; out of reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: A load or store whose index selects a valid line with a matching tag is answered with `rsp_valid` in the cycle after acceptance, and it issues no next-level request.
- R3: Every load returns the most recent value stored to that word address, whether it hits or misses.
- R4: A miss issues exactly one read request (`mem_req_we`=0) whose `mem_req_addr` is the requested word address. The request holds its address until accepted. The beats that follow are placed at offsets off, off+1, off+2, off+3 modulo 4, where off is address bits [1:0].
- R5: On a miss, `rsp_valid` is raised in the cycle after the first beat is taken, while the other three beats are still outstanding.
- R6: A store hit updates only the addressed word and marks the line dirty, with no immediate next-level traffic.
- R7: A store miss fills the line like a load miss, merges the store data over the critical word, and leaves the line dirty.
- R8: Replacing a clean line produces no next-level write.
- R9: Replacing a dirty line produces four write beats (`mem_req_we`=1) to the old line's word addresses with word offsets 0,1,2,3 in that order, each carrying that word's latest data.
- R10: The refill read request of a miss is accepted before any copyback write beat of the same miss.
- R11: `req_ready` stays 0 from the acceptance of a miss until its fill, install and any copyback are complete, and `mem_req_valid` is 0 whenever `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester has a load or store |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW (10) | Word address: tag [9:5], index [4:2], offset [1:0] |
| req_wdata | input | DW (32) | Store data |
| rsp_valid | output | 1 | One-cycle response strobe per accepted request |
| rsp_rdata | output | DW (32) | Load data (meaningless for stores) |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_we | output | 1 | 1 = write beat, 0 = line read |
| mem_req_addr | output | AW (10) | Word address of read or write beat |
| mem_req_wdata | output | DW (32) | Copyback data |
| mem_rsp_valid | input | 1 | Read beat present |
| mem_rsp_rdata | input | DW (32) | Read beat data |

## Verification
The hardest case to reach from the ports is a dirty eviction, where the refill order and the copyback order have to be observed together. To get there, the stimulus first loads a line and stores into it. It then loads an address with the same index but a different tag. This forces a fill and a copyback in one miss, while the next-level model stalls `mem_req_ready` and leaves gaps between beats. A reload of the first address then reads back the copied-back data. A critical offset of 2 checks that the wrapped beats land in the right words. A long random phase over four tags and eight lines then mixes hits, clean evictions and dirty evictions under varying backpressure.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    LN_INVALID = 2'b00,
    LN_CLEAN   = 2'b01,
    LN_DIRTY   = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL_REQ,
    S_FILL_DATA,
    S_INSTALL,
    S_COPYBACK
  } ctl_st_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array
  import wbc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st
);
  logic [TAG_W-1:0] tag_view [LINES];
  line_st_e         st_view  [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic             sel;
    logic [TAG_W-1:0] tag_q;
    line_st_e         st_q;

    assign sel = wr_en && (wr_idx == IDX_W'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= LN_INVALID;
      else if (sel) st_q <= wr_st;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q <= wr_tag;
    end

    assign tag_view[l] = tag_q;
    assign st_view[l]  = st_q;
  end

  assign rd_tag = tag_view[rd_idx];
  assign rd_st  = st_view[rd_idx];

  // an allocation or store never writes the invalid code
  p_write_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_st != LN_INVALID));
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [OFF_W-1:0]           rd_off,
  output logic [DW-1:0]              rd_word,
  output logic [WORDS-1:0][DW-1:0]   rd_line,
  input  logic                       word_we,
  input  logic [IDX_W-1:0]           word_idx,
  input  logic [OFF_W-1:0]           word_off,
  input  logic [DW-1:0]              word_data,
  input  logic                       line_we,
  input  logic [IDX_W-1:0]           line_idx,
  input  logic [WORDS-1:0][DW-1:0]   line_data
);
  logic [DW-1:0] view [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic          en;
      logic [DW-1:0] wd;
      logic [DW-1:0] word_q;

      assign en = (line_we && (line_idx == IDX_W'(l))) ||
                  (word_we && (word_idx == IDX_W'(l)) && (word_off == OFF_W'(w)));
      assign wd = line_we ? line_data[w] : word_data;

      always_ff @(posedge clk) begin
        if (en) word_q <= wd;
      end

      assign view[l][w] = word_q;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign rd_line[w] = view[rd_idx][w];
  end

  assign rd_word = view[rd_idx][rd_off];
endmodule

// File: rtl/wbc_fill_buf.sv
module wbc_fill_buf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     beat_en,
  input  logic [OFF_W-1:0]         beat_pos,
  input  logic [DW-1:0]            beat_data,
  output logic [WORDS-1:0][DW-1:0] line
);
  for (genvar w = 0; w < WORDS; w++) begin : g_slot
    logic [DW-1:0] slot_q;

    always_ff @(posedge clk) begin
      if (beat_en && (beat_pos == OFF_W'(w))) slot_q <= beat_data;
    end

    assign line[w] = slot_q;
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = AW - IDX_W - OFF_W;
  localparam int LINE_A = AW - OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  // request decode
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  assign a_tag = req_addr[AW-1 -: TAG_W];
  assign a_idx = req_addr[OFF_W +: IDX_W];
  assign a_off = req_addr[OFF_W-1:0];

  // state
  ctl_st_e                 st_q, st_d;
  logic [AW-1:0]           rq_addr_q;
  logic                    rq_we_q;
  logic [DW-1:0]           rq_wdata_q;
  logic [OFF_W-1:0]        beat_q, wb_q;
  logic                    vic_pend_q, vic_pend_d, vic_pend_en;
  logic [WORDS-1:0][DW-1:0] vic_line_q;
  logic [LINE_A-1:0]       vic_base_q;
  logic                    fill_issued_q, fill_issued_d;
  logic                    rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]           rsp_data_q, rsp_data_d;

  // array interfaces
  logic [TAG_W-1:0]         rd_tag;
  line_st_e                 rd_st;
  logic                     tag_we;
  logic [IDX_W-1:0]         tag_widx;
  logic [TAG_W-1:0]         tag_wtag;
  line_st_e                 tag_wst;
  logic [DW-1:0]            rd_word;
  logic [WORDS-1:0][DW-1:0] rd_line;
  logic [WORDS-1:0][DW-1:0] fill_line;
  logic                     beat_take;
  logic [OFF_W-1:0]         beat_pos;
  logic [DW-1:0]            beat_data;

  logic accept, hit, miss_acc, vic_cap, fill_hs, wb_hs;
  logic [TAG_W-1:0] rq_tag;
  logic [IDX_W-1:0] rq_idx;
  logic [OFF_W-1:0] rq_off;
  assign rq_tag = rq_addr_q[AW-1 -: TAG_W];
  assign rq_idx = rq_addr_q[OFF_W +: IDX_W];
  assign rq_off = rq_addr_q[OFF_W-1:0];

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = (rd_st != LN_INVALID) && (rd_tag == a_tag);
  assign miss_acc  = accept && !hit;
  assign vic_cap   = miss_acc && (rd_st == LN_DIRTY);
  assign fill_hs   = (st_q == S_FILL_REQ) && mem_req_ready;
  assign wb_hs     = (st_q == S_COPYBACK) && mem_req_ready;
  assign beat_take = (st_q == S_FILL_DATA) && mem_rsp_valid;
  assign beat_pos  = rq_off + beat_q;
  assign beat_data = ((beat_q == '0) && rq_we_q) ? rq_wdata_q : mem_rsp_rdata;

  wbc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (a_idx),
    .rd_tag (rd_tag),
    .rd_st  (rd_st),
    .wr_en  (tag_we),
    .wr_idx (tag_widx),
    .wr_tag (tag_wtag),
    .wr_st  (tag_wst)
  );

  wbc_data_array #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
    .clk       (clk),
    .rd_idx    (a_idx),
    .rd_off    (a_off),
    .rd_word   (rd_word),
    .rd_line   (rd_line),
    .word_we   (accept && hit && req_we),
    .word_idx  (a_idx),
    .word_off  (a_off),
    .word_data (req_wdata),
    .line_we   (st_q == S_INSTALL),
    .line_idx  (rq_idx),
    .line_data (fill_line)
  );

  wbc_fill_buf #(.WORDS(WORDS), .DW(DW)) u_fill (
    .clk       (clk),
    .beat_en   (beat_take),
    .beat_pos  (beat_pos),
    .beat_data (beat_data),
    .line      (fill_line)
  );

  // tag/state update selection
  always_comb begin
    tag_we   = 1'b0;
    tag_widx = a_idx;
    tag_wtag = a_tag;
    tag_wst  = LN_DIRTY;
    if (st_q == S_INSTALL) begin
      tag_we   = 1'b1;
      tag_widx = rq_idx;
      tag_wtag = rq_tag;
      tag_wst  = rq_we_q ? LN_DIRTY : LN_CLEAN;
    end else if (accept && hit && req_we) begin
      tag_we = 1'b1;
    end
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:      if (miss_acc) st_d = S_FILL_REQ;
      S_FILL_REQ:  if (mem_req_ready) st_d = S_FILL_DATA;
      S_FILL_DATA: if (beat_take && (beat_q == LAST)) st_d = S_INSTALL;
      S_INSTALL:   st_d = vic_pend_q ? S_COPYBACK : S_IDLE;
      S_COPYBACK:  if (wb_hs && (wb_q == LAST)) st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  always_comb begin
    vic_pend_en   = vic_cap || (wb_hs && (wb_q == LAST));
    vic_pend_d    = vic_cap;
    fill_issued_d = fill_hs ? 1'b1 : ((st_q == S_IDLE) ? 1'b0 : fill_issued_q);
    rsp_valid_d   = (accept && hit) || (beat_take && (beat_q == '0));
    rsp_data_d    = (st_q == S_IDLE) ? rd_word : mem_rsp_rdata;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      beat_q        <= '0;
      wb_q          <= '0;
      vic_pend_q    <= 1'b0;
      fill_issued_q <= 1'b0;
      rsp_valid_q   <= 1'b0;
    end else begin
      st_q          <= st_d;
      fill_issued_q <= fill_issued_d;
      rsp_valid_q   <= rsp_valid_d;
      if (beat_take)   beat_q     <= beat_q + 1'b1;
      if (wb_hs)       wb_q       <= wb_q + 1'b1;
      if (vic_pend_en) vic_pend_q <= vic_pend_d;
    end
  end

  // datapath registers
  always_ff @(posedge clk) begin
    if (miss_acc) begin
      rq_addr_q  <= req_addr;
      rq_we_q    <= req_we;
      rq_wdata_q <= req_wdata;
    end
    if (vic_cap) begin
      vic_line_q <= rd_line;
      vic_base_q <= {rd_tag, a_idx};
    end
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  // outputs
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;
  assign mem_req_valid = (st_q == S_FILL_REQ) || (st_q == S_COPYBACK);
  assign mem_req_we    = (st_q == S_COPYBACK);
  assign mem_req_addr  = (st_q == S_COPYBACK) ? {vic_base_q, wb_q} : rq_addr_q;
  assign mem_req_wdata = vic_line_q[wb_q];

  // assertions
  p_idle_no_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && !mem_req_valid));

  p_fwd_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_ready) |-> ((st_q == S_FILL_DATA) && (beat_q == OFF_W'(1))));

  p_fill_before_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> fill_issued_q);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !mem_req_we) |=>
      (mem_req_valid && $stable(mem_req_addr) && !mem_req_we));
endmodule

// File: tb/tb_wbc_cache.sv
module tb_wbc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MEM_WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbc_cache #(.AW(AW), .DW(DW), .WORDS(4), .LINES(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] ext_mem [MEM_WORDS];
  logic [DW-1:0] ref_mem [MEM_WORDS];
  int            n_vec = 0;
  int            n_fail = 0;
  int            n_rd = 0;
  int            n_wr = 0;
  logic [AW-1:0] last_acc;

  // next-level model state
  logic              fill_active, fill_seen;
  logic [AW-3:0]     fill_base;
  logic [1:0]        fill_off, wr_idx;
  int                beats_drv, beats_done, lat;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor + next-level memory model, all on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = '0;
      fill_active = 1'b0;
      fill_seen = 1'b0;
      wr_idx = '0;
      beats_drv = 0;
      beats_done = 0;
      lat = 0;
    end else begin
      if (mem_rsp_valid) begin
        beats_done++;
        if (beats_done == 4) fill_active = 1'b0;
      end
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 response with nothing outstanding", rsp_rdata, '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (!e.we) chk(rsp_rdata == e.data, "R3 load data", rsp_rdata, e.data);
        end
        if (fill_active) chk(beats_done == 1, "R5 forward after first beat", beats_done, 1);
      end
      if (fill_active) chk(!req_ready, "R11 ready low during fill", {31'b0, req_ready}, 0);
      if (req_ready) fill_seen = 1'b0;

      mem_rsp_valid = 1'b0;
      if (fill_active && beats_drv < 4) begin
        if (lat > 0) lat--;
        else if (($urandom % 3) != 0) begin
          logic [1:0] o;
          o = fill_off + 2'(beats_drv);
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = ext_mem[{fill_base, o}];
          beats_drv++;
        end
      end

      mem_req_ready = (($urandom % 4) != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_we) begin
          chk(mem_req_addr == last_acc, "R4 read carries requested word", 32'(mem_req_addr), 32'(last_acc));
          fill_active = 1'b1;
          fill_seen = 1'b1;
          fill_base = mem_req_addr[AW-1:2];
          fill_off = mem_req_addr[1:0];
          beats_drv = 0;
          beats_done = 0;
          lat = 2;
          n_rd++;
        end else begin
          chk(fill_seen, "R10 refill before copyback", {31'b0, fill_seen}, 1);
          chk(mem_req_addr[1:0] == wr_idx, "R9 copyback order", 32'(mem_req_addr[1:0]), 32'(wr_idx));
          chk(mem_req_wdata == ref_mem[mem_req_addr], "R9 copyback data", mem_req_wdata, ref_mem[mem_req_addr]);
          ext_mem[mem_req_addr] = mem_req_wdata;
          wr_idx = wr_idx + 2'd1;
          n_wr++;
        end
      end
    end
  end

  task automatic do_req(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = addr;
    req_wdata = data;
    while (!req_ready) @(negedge clk);
    e.we = we;
    e.addr = addr;
    e.data = we ? data : ref_mem[addr];
    sb_q.push_back(e);
    last_acc = addr;
    if (we) ref_mem[addr] = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while ((sb_q.size() != 0 || !req_ready) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 2000, "R11 controller returns to idle", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int rd0, wr0;
    for (int i = 0; i < MEM_WORDS; i++) begin
      ext_mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0101);
      ref_mem[i] = ext_mem[i];
    end
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    // R1 R3 R4 R5: cold load miss with critical offset 2
    rd0 = n_rd;
    do_req(1'b0, 10'h006, '0);
    wait_idle();
    chk(n_rd == rd0 + 1, "R1 first access reads memory", n_rd, rd0 + 1);

    // R2 R4: other words of the line are hits, correctly placed
    rd0 = n_rd;
    do_req(1'b0, 10'h004, '0);
    do_req(1'b0, 10'h005, '0);
    do_req(1'b0, 10'h007, '0);
    do_req(1'b1, 10'h005, 32'hDEAD_0005);   // R6 store hit
    do_req(1'b0, 10'h005, '0);
    wait_idle();
    chk(n_rd == rd0, "R2 R6 hits make no memory read", n_rd, rd0);
    chk(n_wr == 0, "R6 store hit makes no write", n_wr, 0);

    // R9 R10: dirty eviction by a conflicting tag
    wr0 = n_wr;
    do_req(1'b0, 10'h025, '0);
    wait_idle();
    chk(n_wr == wr0 + 4, "R9 dirty line written back", n_wr, wr0 + 4);
    chk(ext_mem[10'h005] == 32'hDEAD_0005, "R9 store data reached memory", ext_mem[10'h005], 32'hDEAD_0005);

    // R8: line 0x024 is clean, evicting it writes nothing
    wr0 = n_wr;
    do_req(1'b0, 10'h005, '0);
    wait_idle();
    chk(n_wr == wr0, "R8 clean eviction silent", n_wr, wr0);

    // R7: store miss allocates and dirties
    rd0 = n_rd;
    do_req(1'b1, 10'h04B, 32'hCAFE_004B);
    do_req(1'b0, 10'h04B, '0);
    do_req(1'b0, 10'h048, '0);
    do_req(1'b0, 10'h049, '0);
    wait_idle();
    chk(n_rd == rd0 + 1, "R7 store miss fills once", n_rd, rd0 + 1);
    wr0 = n_wr;
    do_req(1'b0, 10'h068, '0);
    wait_idle();
    chk(n_wr == wr0 + 4, "R7 store-miss line left dirty", n_wr, wr0 + 4);

    // mixed traffic over four tags
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 128);
      do_req(($urandom % 3) == 0, a, $urandom);
    end
    wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule